// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer Channel

This block is one counter/timer channel dedicated to a single processor. A mode bit, supplied from a system-level mode register outside the block, selects between two personalities. In timer mode the channel counts toward a programmable limit. When the count reaches the limit, a sticky reached flag and a local interrupt are raised and the count restarts from zero. A limit of zero turns the channel into a free-running counter with no match. In user mode the same register window becomes a 63-bit counter. Software can preload it, start it and stop it, and it is read as two 32-bit halves. In this mode the channel never interrupts.

Counting is paced by an external tick strobe, nominally one pulse every 500 ns. Each tick adds one unit of weight 2^9, so the nine least significant bits of every count are always zero. Software reaches the channel through a plain single-cycle register port. A 2-bit word select addresses four 32-bit registers: index 0 is limit or high half, 1 is count or low half, 2 is limit without restart, 3 is run control. Reads return data combinationally in the same cycle. Read and write side effects take place on the following clock edge. No data streams through the block, so the port has no valid/ready handshake and never applies back-pressure. Every access completes in one cycle.

Top module: `tmr_chan`

## Requirements
- R1: After reset the channel is in timer mode, the run bit reads 1, the limit is zero (free-run), the count is zero, the reached flag is clear and the interrupt is low.
- R2: In timer mode a write to word 0 stores wdata[30:9] as the limit, restarts the count from zero and lowers the interrupt.
- R3: In timer mode with a nonzero limit, the tick that would bring the count to the limit instead sets the reached flag and the interrupt, and returns the count to zero. Reached is visible as bit 31 of a word 1 read.
- R4: In timer mode a read of word 0 returns the limit in bits 30:9 and clears both the reached flag and the interrupt. A new match in the same cycle takes priority over the clear.
- R5: With a zero limit in timer mode the count never sets reached or the interrupt. It wraps to zero at 0x7FFFFE00.
- R6: A write to word 2 stores wdata[30:9] as the limit without restarting the count. Word 2 reads as zero.
- R7: In timer mode the run bit is stored but does not stop counting, and writes to word 1 are ignored.
- R8: In user mode a word 0 read returns the reached flag in bit 31 over count bits 62:32, and does not clear reached. A word 1 read returns count bits 31:0, with bits 8:0 zero.
- R9: In user mode a word 0 write loads count bits 62:32 from wdata[30:0]. A word 1 write loads count bits 31:9 from wdata[31:9], and wdata[8:0] is ignored. Both writes clear reached and counting continues from the loaded value.
- R10: In user mode the count wraps to zero on reaching 0x7FFFFFFFFFFFFE00 and sets reached. The interrupt is never asserted in user mode.
- R11: Word 3 stores wdata[0] as the run bit and reads it back in bit 0. In user mode the count advances only while the run bit is 1.
- R12: When the mode bit changes from timer to user, the interrupt is lowered and the count restarts from zero. From then on it advances only if the run bit is 1.
- R13: When the mode bit changes from user to timer, the count restarts from zero and advances on every tick regardless of the run bit.
- R14: Each enabled tick adds 2^9 to the count, and a carry out of bit 31 propagates into the high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one pulse per count unit |
| user_mode | input | 1 | Mode bit from the system mode register, 1 selects user mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| sel | input | 2 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected word, combinational |
| irq | output | 1 | Local interrupt, level |

## Verification
Most internal faults reach the ports within one clock. A wrong count or limit shows up on the next read of word 0 or word 1. A wrong reached or interrupt state shows on the irq pin in the cycle after the faulty edge, or on bit 31 of the next read. A fault in the mode edge detector or in run gating is visible only as a count that fails to restart or fails to hold. The reference model is therefore compared on irq in every cycle, and the count is read back after each mode change and each run or stop write. Terminal and wrap faults lie far from zero, so the counter is preloaded three units below the user-mode maximum to reach them within a few ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_HI_LIM = 2'd0,
    SEL_LO_CNT = 2'd1,
    SEL_LIM_NR = 2'd2,
    SEL_RUN    = 2'd3
  } tmr_sel_e;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CU = 54
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CU-1:0] load_val,
  input  logic          inc,
  input  logic          match_en,
  input  logic [CU-1:0] term_match,
  input  logic [CU-1:0] term_roll,
  output logic [CU-1:0] cnt,
  output logic          hit
);
  logic at_match, at_roll;

  assign at_match = match_en && (cnt == term_match);
  assign at_roll  = (cnt == term_roll);
  assign hit      = inc && !clr && !load && at_match;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (inc) begin
      if (at_match || at_roll) cnt <= '0;
      else                     cnt <= cnt + CU'(1);
    end
  end

  // R2 / R12 / R13: a restart request leaves the count at zero
  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R11: with no load, restart or enabled tick the count holds
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !inc) |=> $stable(cnt));

  // R3: a match always lands the count at zero
  assert_match_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic user,
  input  logic user_q,
  input  logic hit,
  input  logic ack,
  input  logic irq_drop,
  input  logic reach_clr,
  output logic reached,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (hit)                    reached <= 1'b1;
      else if (ack || reach_clr)  reached <= 1'b0;
      if (hit && !user)           irq <= 1'b1;
      else if (ack || irq_drop)   irq <= 1'b0;
    end
  end

  // R10: no interrupt while settled in user mode
  assert_no_irq_user_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (user && user_q) |-> !irq);

  // R4: an acknowledge with no new match clears both flags
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> (!irq && !reached));

  // R3: a match leaves reached set
  assert_hit_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> reached);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import tmr_pkg::*;

  localparam int TMR_W  = DATA_W - 1;
  localparam int WIDE_W = 2 * DATA_W - 1;
  localparam int TU     = TMR_W - FRAC_W;
  localparam int CU     = WIDE_W - FRAC_W;
  localparam int LO_U   = DATA_W - FRAC_W;
  localparam int HI_W   = WIDE_W - DATA_W;

  localparam logic [CU-1:0] USER_TERM = ~(CU'(1));
  localparam logic [CU-1:0] TMR_ROLL  = {{(CU-TU){1'b0}}, {(TU-1){1'b1}}, 1'b0};

  tmr_sel_e      rsel;
  logic          mode_q, run_q, xit;
  logic [TU-1:0] lim_q;
  logic [CU-1:0] cnt, load_val, term_match, term_roll;
  logic          clr, load, inc, hit, match_en;
  logic          ack, irq_drop, reach_clr, reached;

  assign rsel = tmr_sel_e'(sel);
  assign xit  = (user_mode != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      run_q  <= 1'b1;
      lim_q  <= '0;
    end else begin
      mode_q <= user_mode;
      if (wr_en && rsel == SEL_RUN) run_q <= wdata[0];
      if (wr_en && (rsel == SEL_LIM_NR || (rsel == SEL_HI_LIM && !user_mode)))
        lim_q <= wdata[TMR_W-1:FRAC_W];
    end
  end

  // counter control
  assign clr  = xit || (wr_en && !user_mode && rsel == SEL_HI_LIM);
  assign load = wr_en && user_mode && (rsel == SEL_HI_LIM || rsel == SEL_LO_CNT);
  assign inc  = tick && (!user_mode || run_q);

  always_comb begin
    if (rsel == SEL_HI_LIM) load_val = {wdata[HI_W-1:0], cnt[LO_U-1:0]};
    else                    load_val = {cnt[CU-1:LO_U], wdata[DATA_W-1:FRAC_W]};
  end

  always_comb begin
    if (user_mode) begin
      match_en   = 1'b1;
      term_match = USER_TERM;
      term_roll  = USER_TERM;
    end else begin
      match_en   = (lim_q != '0);
      term_match = {{(CU-TU){1'b0}}, lim_q} - CU'(1);
      term_roll  = TMR_ROLL;
    end
  end

  tmr_count #(.CU(CU)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .load       (load),
    .load_val   (load_val),
    .inc        (inc),
    .match_en   (match_en),
    .term_match (term_match),
    .term_roll  (term_roll),
    .cnt        (cnt),
    .hit        (hit)
  );

  // flag control
  assign ack       = rd_en && !user_mode && rsel == SEL_HI_LIM;
  assign irq_drop  = (wr_en && !user_mode && rsel == SEL_HI_LIM) || (xit && user_mode);
  assign reach_clr = load;

  tmr_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .user      (user_mode),
    .user_q    (mode_q),
    .hit       (hit),
    .ack       (ack),
    .irq_drop  (irq_drop),
    .reach_clr (reach_clr),
    .reached   (reached),
    .irq       (irq)
  );

  // read mux
  always_comb begin
    unique case (rsel)
      SEL_HI_LIM: rdata = user_mode ? {reached, cnt[CU-1:LO_U]}
                                    : {1'b0, lim_q, {FRAC_W{1'b0}}};
      SEL_LO_CNT: rdata = user_mode ? {cnt[LO_U-1:0], {FRAC_W{1'b0}}}
                                    : {reached, cnt[TU-1:0], {FRAC_W{1'b0}}};
      SEL_RUN:    rdata = {{(DATA_W-1){1'b0}}, run_q};
      default:    rdata = '0;
    endcase
  end

  // R8: the low word never shows bits below the count unit
  assert_low_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == SEL_LO_CNT) |-> (rdata[FRAC_W-1:0] == '0));

  // R6: the no-restart limit word always reads as zero
  assert_limnr_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == SEL_LIM_NR) |-> (rdata == '0));
endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        user_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  longint unsigned m_cnt;   // count in units of 512
  int unsigned     m_lim;   // limit in units of 512
  bit m_run, m_reach, m_irq, m_mq;

  localparam longint unsigned USER_MAX_U = (64'd1 << 54) - 64'd1;
  localparam longint unsigned TMR_FULL_U = 64'h3FFFFF;

  always #5 clk = ~clk;

  tmr_chan u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
    .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] s, input bit user);
    longint unsigned v;
    v = m_cnt * 512;
    case (s)
      2'd0: exp_rd = user ? (32'(v / 64'h1_0000_0000) | (32'(m_reach) << 31))
                          : 32'(m_lim) * 512;
      2'd1: exp_rd = user ? 32'(v % 64'h1_0000_0000)
                          : (32'(v % 64'h8000_0000) | (32'(m_reach) << 31));
      2'd3: exp_rd = 32'(m_run);
      default: exp_rd = 32'd0;
    endcase
  endfunction

  task automatic model_update(input bit wr, input bit rd, input logic [1:0] s,
                              input logic [31:0] d, input bit tk);
    bit user, xit;
    longint unsigned nxt;
    user = user_mode;
    xit  = (user != m_mq);
    if (rd && !user && s == 2'd0) begin m_reach = 0; m_irq = 0; end
    if (wr && !user && s == 2'd0) m_irq = 0;
    if (wr && user && s < 2'd2) m_reach = 0;
    if (xit && user) m_irq = 0;
    if (wr && (s == 2'd2 || (s == 2'd0 && !user))) m_lim = (d / 512) % 32'h40_0000;
    if (wr && s == 2'd3) m_run = d[0];
    if (xit) m_cnt = 0;
    else if (wr && !user && s == 2'd0) m_cnt = 0;
    else if (wr && user && s == 2'd0)
      m_cnt = longint'(d % 32'h8000_0000) * 64'h80_0000 + (m_cnt % 64'h80_0000);
    else if (wr && user && s == 2'd1)
      m_cnt = (m_cnt / 64'h80_0000) * 64'h80_0000 + longint'(d / 512);
    else if (tk && (!user || m_run)) begin
      nxt = m_cnt + 1;
      if (user && nxt == USER_MAX_U) begin m_cnt = 0; m_reach = 1; end
      else if (!user && m_lim != 0 && nxt == longint'(m_lim)) begin
        m_cnt = 0; m_reach = 1; m_irq = 1;
      end
      else if (!user && nxt == TMR_FULL_U) m_cnt = 0;
      else m_cnt = nxt;
    end
    m_mq = user;
  endtask

  // one clock: drive at negedge, compare, then advance model at posedge
  task automatic step(input string tag, input bit wr, input bit rd,
                      input logic [1:0] s, input logic [31:0] d, input bit tk);
    wr_en = wr; rd_en = rd; sel = s; wdata = d; tick = tk;
    #1;
    chk(tag, "irq", {31'd0, irq}, {31'd0, m_irq});
    if (rd) chk(tag, "rdata", rdata, exp_rd(s, user_mode));
    @(posedge clk);
    model_update(wr, rd, s, d, tk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick = 0;
  endtask

  task automatic idle(input string tag, input int n, input bit tk);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 2'd0, 32'd0, tk);
  endtask

  task automatic rd(input string tag, input logic [1:0] s);
    step(tag, 0, 1, s, 32'd0, 0);
  endtask

  task automatic wr(input string tag, input logic [1:0] s, input logic [31:0] d);
    step(tag, 1, 0, s, d, 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    m_cnt = 0; m_lim = 0; m_run = 1; m_reach = 0; m_irq = 0; m_mq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd3); rd("R1", 2'd2);
    // R14 one unit per tick
    idle("R14", 5, 1); rd("R14", 2'd1);
    // R7 run bit ignored in timer mode, word 1 write ignored
    wr("R7", 2'd3, 32'd0); rd("R7", 2'd3);
    idle("R7", 3, 1); rd("R7", 2'd1);
    wr("R7", 2'd1, 32'h1234_5600); rd("R7", 2'd1);
    // R2 limit write restarts, R3 match, R4 acknowledge
    wr("R2", 2'd0, 32'h0000_0BFF); rd("R2", 2'd1); rd("R2", 2'd0);
    idle("R3", 4, 1); rd("R3", 2'd1);
    idle("R3", 1, 1); rd("R3", 2'd1);
    idle("R3", 3, 1);
    rd("R4", 2'd0); rd("R4", 2'd1);
    idle("R3", 12, 1); rd("R3", 2'd1);
    // R4 ack and match in the same cycle: match wins
    idle("R4", 2, 1);
    step("R4", 0, 1, 2'd0, 32'd0, 1); rd("R4", 2'd1);
    rd("R4", 2'd0);
    // R6 limit without restart
    wr("R6", 2'd0, 32'h0000_2800);
    idle("R6", 8, 1);
    wr("R6", 2'd2, 32'h0000_1800); rd("R6", 2'd1); rd("R6", 2'd2);
    idle("R6", 5, 1); rd("R6", 2'd1); rd("R6", 2'd0);
    idle("R6", 3, 1);
    wr("R6", 2'd2, 32'h0000_0400);
    idle("R6", 20, 1); rd("R6", 2'd1);
    // R5 free-run
    wr("R5", 2'd0, 32'd0);
    idle("R5", 50, 1); rd("R5", 2'd1);
    // R12 timer->user with irq pending and run clear
    wr("R12", 2'd0, 32'h0000_0600);
    idle("R12", 3, 1);
    user_mode = 1'b1;
    idle("R12", 1, 1);
    idle("R12", 4, 1); rd("R12", 2'd1); rd("R12", 2'd0);
    // R11 run control in user mode
    wr("R11", 2'd3, 32'hFFFF_FFFF); rd("R11", 2'd3);
    idle("R11", 6, 1); rd("R11", 2'd1);
    wr("R11", 2'd3, 32'h0000_0002); rd("R11", 2'd3);
    idle("R11", 6, 1); rd("R11", 2'd1);
    wr("R11", 2'd3, 32'd1);
    // R9 loads, R10 wrap at maximum, R8 reads
    wr("R9", 2'd0, 32'hFFFF_FFFF);
    wr("R9", 2'd1, 32'hFFFF_F9FF); rd("R9", 2'd0); rd("R9", 2'd1);
    idle("R10", 2, 1); rd("R10", 2'd1);
    idle("R10", 1, 1); rd("R10", 2'd0); rd("R8", 2'd0); rd("R8", 2'd1);
    idle("R10", 5, 1);
    wr("R9", 2'd1, 32'h0000_0000); rd("R9", 2'd0);
    // R14 carry into the high half
    wr("R14", 2'd0, 32'h0000_0005);
    wr("R14", 2'd1, 32'hFFFF_FE00);
    idle("R14", 1, 1); rd("R14", 2'd0); rd("R14", 2'd1);
    // R13 user->timer starts counting even with run clear
    wr("R13", 2'd3, 32'd0);
    user_mode = 1'b0;
    idle("R13", 1, 1);
    idle("R13", 4, 1); rd("R13", 2'd1); rd("R13", 2'd3);
    idle("R13", 4, 0);
    summary();
  end
endmodule